// File: doc/BRIEF.md
# Multiple Header Error Log Queue

This block keeps the header-logging state of an advanced error reporting capability for a single function. It owns the uncorrectable error status register, the first-error pointer, a four-word header log, a four-word prefix log and a prefix-present bit. Behind these registers sits a small register FIFO that holds uncorrectable errors which arrive while an earlier error is still awaiting software attention. Severity classification and message generation live elsewhere. The block only decides where each error is logged and when the next one becomes visible.

An error is presented for one cycle on the record inputs as a one-hot status vector, a header-valid flag, a prefix flag, four header words and four prefix words. When multiple-header recording is active and the error pointed at by the first-error pointer has not yet been cleared, the new error waits in the FIFO. Otherwise it goes straight into the log registers. Software clears status bits with write-one-to-clear writes. When such a write clears the current first-error bit, the oldest queued error is promoted into the log. If an error arrives while the FIFO is full, it is dropped and a one-cycle overflow pulse is raised. The surrounding logic turns that pulse into a correctable header-log-overflow error.

Top module: `mh_err_log_queue`

## Requirements
- R1: A record whose status vector does not have exactly one bit set is ignored. No output and no queue state changes because of it.
- R2: A valid record is loaded directly into the log when multiple recording is inactive or when status bit [first-error pointer] is clear. The pointer takes the index of the set bit. In every case the status bit of a valid record becomes set. All outputs are registered and change on the edge that samples the record. While multi_en is low, the queue never grows.
- R3: A valid record that is not loaded directly is appended to the FIFO. If the FIFO already holds LOG_MAX entries, the record is dropped and ovf_pulse is high for exactly the one cycle after that edge. The record's status bit is still set.
- R4: Loading an entry copies its four header words when its header-valid flag is 1 and zeroes the header log when the flag is 0. Word i occupies bits [32i+31:32i] in both rec_hdr and hdr_log.
- R5: Loading an entry sets pfx_present and copies the prefix words only when the entry has a prefix and prefix_sup is 1 in the load cycle. Otherwise pfx_present is 0 and the prefix log is zero.
- R6: A status write (new status = old & ~sts_wdata) that clears the first-error bit while multiple recording is inactive or the FIFO is empty sets the pointer, pfx_present, header log and prefix log to zero.
- R7: A status write that clears the first-error bit while multiple recording is active and the FIFO is non-empty re-asserts the status bit of every queued entry, including the oldest one. It then pops the oldest entry and loads it, so entries leave in arrival order.
- R8: A status write that leaves the first-error bit set while multiple recording is active re-asserts the status bits of all queued entries.
- R9: A status write that leaves the first-error bit set while multi_en is low empties the FIFO.
- R10: multi_cap is 1 exactly when LOG_MAX is greater than zero. Multiple recording is active only when multi_en and multi_cap are both 1.
- R11: After reset, the status register, pointer, logs, pfx_present and ovf_pulse are zero, and the FIFO is empty.
- R12: When a status write and a record occur in the same cycle, the write is applied first and the record is then handled against the state that results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| multi_en | input | 1 | Multiple-header recording enable from the control register |
| prefix_sup | input | 1 | End-to-end prefix support advertised |
| rec_valid | input | 1 | Record strobe, one cycle per error |
| rec_status | input | STS_W | One-hot uncorrectable status code of the error |
| rec_hdr_valid | input | 1 | Header words of the error are valid |
| rec_has_prefix | input | 1 | Error carries prefix words |
| rec_hdr | input | WORD_W*WORDS | Header words, word 0 lowest |
| rec_prefix | input | WORD_W*WORDS | Prefix words, word 0 lowest |
| sts_wr | input | 1 | Software write to the uncorrectable status register |
| sts_wdata | input | STS_W | Write-one-to-clear data |
| uncor_sts | output | STS_W | Uncorrectable error status register |
| fep | output | FEP_W | First-error pointer |
| hdr_log | output | WORD_W*WORDS | Header log |
| pfx_log | output | WORD_W*WORDS | Prefix log |
| pfx_present | output | 1 | Prefix log holds a valid prefix |
| multi_cap | output | 1 | Multiple-header recording capable |
| ovf_pulse | output | 1 | One-cycle pulse on a dropped record |

## Verification
Directed sequences cover a set of cases that the random traffic would rarely hit. A record that arrives while the first-error bit is cleared takes the direct-load path, and one that arrives while the bit is held takes the queue path. A partial clear aimed only at a queued entry shows re-assertion rather than a pop. A full FIFO shows the overflow drop, and draining it afterwards shows arrival-order popping. A flush with multi_en low is told apart from a pop by re-enabling recording before the clearing write. A write and a record in the same cycle show write-first ordering. Random traffic then concentrates status codes on a few low bits, so records collide with the current first error. It mixes writes aimed at the first error with writes of arbitrary masks, and toggles multi_en and prefix_sup. Every output is compared each cycle with a bench model, which separates the direct-load, queue, pop, re-assert and flush paths.

// File: rtl/mh_err_log_queue.sv
module mh_err_log_queue #(
  parameter int LOG_MAX = 8,
  parameter int STS_W   = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      multi_en,
  input  logic                      prefix_sup,
  input  logic                      rec_valid,
  input  logic [STS_W-1:0]          rec_status,
  input  logic                      rec_hdr_valid,
  input  logic                      rec_has_prefix,
  input  logic [WORD_W*WORDS-1:0]   rec_hdr,
  input  logic [WORD_W*WORDS-1:0]   rec_prefix,
  input  logic                      sts_wr,
  input  logic [STS_W-1:0]          sts_wdata,
  output logic [STS_W-1:0]          uncor_sts,
  output logic [$clog2(STS_W)-1:0]  fep,
  output logic [WORD_W*WORDS-1:0]   hdr_log,
  output logic [WORD_W*WORDS-1:0]   pfx_log,
  output logic                      pfx_present,
  output logic                      multi_cap,
  output logic                      ovf_pulse
);

  localparam int FEP_W = $clog2(STS_W);
  localparam int LOG_W = WORD_W * WORDS;
  localparam int QD    = (LOG_MAX > 0) ? LOG_MAX : 1;
  localparam int PTR_W = (QD > 1) ? $clog2(QD) : 1;
  localparam int CNT_W = $clog2(QD + 1);

  logic [FEP_W-1:0] q_idx [QD];
  logic             q_hv  [QD];
  logic             q_pp  [QD];
  logic [LOG_W-1:0] q_hdr [QD];
  logic [LOG_W-1:0] q_pfx [QD];
  logic [PTR_W-1:0] head;
  logic [CNT_W-1:0] count;

  logic             multi_act, rec_ok;
  logic [FEP_W-1:0] rec_idx;
  logic [STS_W-1:0] q_mask;

  logic [STS_W-1:0] n_sts;
  logic [FEP_W-1:0] n_fep;
  logic [LOG_W-1:0] n_hdr, n_pfx;
  logic             n_pp, n_ovf, push;
  logic [PTR_W-1:0] n_head, push_slot;
  logic [CNT_W-1:0] n_count;

  function automatic logic [PTR_W-1:0] wrap(input int v);
    return PTR_W'((v >= QD) ? v - QD : v);
  endfunction

  assign multi_cap = (LOG_MAX > 0);
  assign multi_act = multi_en & multi_cap;
  assign rec_ok    = (rec_status != '0) &&
                     ((rec_status & (rec_status - STS_W'(1))) == '0);

  always_comb begin
    rec_idx = '0;
    for (int i = 0; i < STS_W; i++)
      if (rec_status[i]) rec_idx = FEP_W'(i);
  end

  always_comb begin
    q_mask = '0;
    for (int k = 0; k < QD; k++)
      if (k < int'(count)) q_mask[q_idx[wrap(int'(head) + k)]] = 1'b1;
  end

  always_comb begin
    n_sts     = uncor_sts;
    n_fep     = fep;
    n_hdr     = hdr_log;
    n_pfx     = pfx_log;
    n_pp      = pfx_present;
    n_head    = head;
    n_count   = count;
    n_ovf     = 1'b0;
    push      = 1'b0;
    push_slot = '0;

    if (sts_wr) begin
      n_sts = uncor_sts & ~sts_wdata;
      if (!n_sts[fep]) begin
        if (!multi_act || count == '0) begin
          n_fep = '0;
          n_hdr = '0;
          n_pfx = '0;
          n_pp  = 1'b0;
        end else begin
          n_sts   = n_sts | q_mask;
          n_fep   = q_idx[head];
          n_hdr   = q_hv[head] ? q_hdr[head] : '0;
          n_pp    = q_pp[head] & prefix_sup;
          n_pfx   = n_pp ? q_pfx[head] : '0;
          n_head  = wrap(int'(head) + 1);
          n_count = count - CNT_W'(1);
        end
      end else if (multi_act) begin
        n_sts = n_sts | q_mask;
      end else begin
        n_count = '0;
        n_head  = '0;
      end
    end

    if (rec_valid && rec_ok) begin
      if (multi_act && n_sts[n_fep]) begin
        if (int'(n_count) >= LOG_MAX) begin
          n_ovf = 1'b1;
        end else begin
          push      = 1'b1;
          push_slot = wrap(int'(n_head) + int'(n_count));
          n_count   = n_count + CNT_W'(1);
        end
      end else begin
        n_fep = rec_idx;
        n_hdr = rec_hdr_valid ? rec_hdr : '0;
        n_pp  = rec_has_prefix & prefix_sup;
        n_pfx = n_pp ? rec_prefix : '0;
      end
      n_sts = n_sts | rec_status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uncor_sts   <= '0;
      fep         <= '0;
      hdr_log     <= '0;
      pfx_log     <= '0;
      pfx_present <= 1'b0;
      ovf_pulse   <= 1'b0;
      head        <= '0;
      count       <= '0;
    end else begin
      uncor_sts   <= n_sts;
      fep         <= n_fep;
      hdr_log     <= n_hdr;
      pfx_log     <= n_pfx;
      pfx_present <= n_pp;
      ovf_pulse   <= n_ovf;
      head        <= n_head;
      count       <= n_count;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_idx[push_slot] <= rec_idx;
      q_hv[push_slot]  <= rec_hdr_valid;
      q_pp[push_slot]  <= rec_has_prefix;
      q_hdr[push_slot] <= rec_hdr;
      q_pfx[push_slot] <= rec_prefix;
    end
  end

endmodule

// File: rtl/mh_err_log_queue_chk.sv
module mh_err_log_queue_chk #(
  parameter int LOG_MAX = 8,
  parameter int STS_W   = 32,
  parameter int LOG_W   = 128,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             multi_en,
  input logic             prefix_sup,
  input logic             rec_valid,
  input logic             sts_wr,
  input logic [STS_W-1:0] uncor_sts,
  input logic [LOG_W-1:0] pfx_log,
  input logic             pfx_present,
  input logic             ovf_pulse,
  input logic [CNT_W-1:0] count
);

  assert_ovf_after_record_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(rec_valid));

  assert_queue_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= LOG_MAX);

  assert_pfx_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_present |-> (pfx_log == '0));

  assert_pfx_needs_support_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_present && !$past(pfx_present)) |-> $past(prefix_sup));

  assert_no_queue_growth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(multi_en) |-> (count <= $past(count)));

  assert_sts_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((uncor_sts & ~$past(uncor_sts)) != '0) |-> ($past(rec_valid) || $past(sts_wr)));

endmodule

bind mh_err_log_queue mh_err_log_queue_chk #(
  .LOG_MAX(LOG_MAX), .STS_W(STS_W), .LOG_W(WORD_W * WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .multi_en(multi_en), .prefix_sup(prefix_sup),
  .rec_valid(rec_valid), .sts_wr(sts_wr), .uncor_sts(uncor_sts),
  .pfx_log(pfx_log), .pfx_present(pfx_present), .ovf_pulse(ovf_pulse),
  .count(count)
);

// File: tb/tb_mh_err_log_queue.sv
module tb_mh_err_log_queue;
  localparam int LM = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         multi_en = 1'b0, prefix_sup = 1'b0;
  logic         rec_valid = 1'b0, rec_hdr_valid = 1'b0, rec_has_prefix = 1'b0;
  logic [31:0]  rec_status = '0;
  logic [127:0] rec_hdr = '0, rec_prefix = '0;
  logic         sts_wr = 1'b0;
  logic [31:0]  sts_wdata = '0;
  logic [31:0]  uncor_sts;
  logic [4:0]   fep;
  logic [127:0] hdr_log, pfx_log;
  logic         pfx_present, multi_cap, ovf_pulse;

  mh_err_log_queue dut (
    .clk(clk), .rst_n(rst_n), .multi_en(multi_en), .prefix_sup(prefix_sup),
    .rec_valid(rec_valid), .rec_status(rec_status), .rec_hdr_valid(rec_hdr_valid),
    .rec_has_prefix(rec_has_prefix), .rec_hdr(rec_hdr), .rec_prefix(rec_prefix),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .uncor_sts(uncor_sts), .fep(fep),
    .hdr_log(hdr_log), .pfx_log(pfx_log), .pfx_present(pfx_present),
    .multi_cap(multi_cap), .ovf_pulse(ovf_pulse)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0;

  logic [31:0]  ms;
  logic [4:0]   mf;
  logic [127:0] mh, mp;
  bit           mpp, mov;
  logic [4:0]   qi [LM];
  bit           qhv [LM], qpp [LM];
  logic [127:0] qh [LM], qp [LM];
  int           qhd, qc;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    ms = '0; mf = '0; mh = '0; mp = '0; mpp = 0; mov = 0; qhd = 0; qc = 0;
  endtask

  task automatic model_step();
    logic [31:0] qm;
    int idx;
    qm = '0;
    for (int k = 0; k < qc; k++) qm[qi[(qhd + k) % LM]] = 1'b1;
    mov = 0;
    if (sts_wr) begin
      ms = ms & ~sts_wdata;
      if (!ms[mf]) begin
        if (!multi_en || qc == 0) begin
          mf = '0; mh = '0; mp = '0; mpp = 0;
        end else begin
          ms  = ms | qm;
          mf  = qi[qhd];
          mh  = qhv[qhd] ? qh[qhd] : '0;
          mpp = qpp[qhd] && prefix_sup;
          mp  = mpp ? qp[qhd] : '0;
          qhd = (qhd + 1) % LM;
          qc  = qc - 1;
        end
      end else if (multi_en) begin
        ms = ms | qm;
      end else begin
        qc = 0; qhd = 0;
      end
    end
    if (rec_valid && $countones(rec_status) == 1) begin
      idx = 0;
      for (int i = 0; i < 32; i++) if (rec_status[i]) idx = i;
      if (multi_en && ms[mf]) begin
        if (qc >= LM) mov = 1;
        else begin
          qi[(qhd + qc) % LM]  = 5'(idx);
          qhv[(qhd + qc) % LM] = rec_hdr_valid;
          qpp[(qhd + qc) % LM] = rec_has_prefix;
          qh[(qhd + qc) % LM]  = rec_hdr;
          qp[(qhd + qc) % LM]  = rec_prefix;
          qc = qc + 1;
        end
      end else begin
        mf  = 5'(idx);
        mh  = rec_hdr_valid ? rec_hdr : '0;
        mpp = rec_has_prefix && prefix_sup;
        mp  = mpp ? rec_prefix : '0;
      end
      ms = ms | rec_status;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #1;
    chk(uncor_sts == ms, "R2 R7 R8 status", 128'(uncor_sts), 128'(ms));
    chk(fep == mf, "R2 R7 pointer", 128'(fep), 128'(mf));
    chk(hdr_log == mh, "R4 header", hdr_log, mh);
    chk(pfx_log == mp && pfx_present == mpp, "R5 prefix", pfx_log, mp);
    chk(ovf_pulse == mov, "R3 overflow", 128'(ovf_pulse), 128'(mov));
    rec_valid = 1'b0;
    sts_wr    = 1'b0;
  endtask

  task automatic rec(input logic [31:0] st, input bit hv, input bit hp);
    rec_valid      = 1'b1;
    rec_status     = st;
    rec_hdr_valid  = hv;
    rec_has_prefix = hp;
    rec_hdr        = {$urandom, $urandom, $urandom, $urandom};
    rec_prefix     = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic wr(input logic [31:0] m);
    sts_wr    = 1'b1;
    sts_wdata = m;
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] h_a;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(uncor_sts == 0 && fep == 0 && hdr_log == 0 && pfx_log == 0 && !pfx_present && !ovf_pulse,
        "R11 reset state", 128'(uncor_sts), 0);
    chk(multi_cap == 1'b1, "R10 capability", 128'(multi_cap), 1);

    rec(32'h0, 1, 1); cyc();
    chk(uncor_sts == 0 && fep == 0 && hdr_log == 0, "R1 zero status ignored", 128'(uncor_sts), 0);
    rec(32'h11, 1, 1); cyc();
    chk(uncor_sts == 0 && fep == 0, "R1 two-bit status ignored", 128'(uncor_sts), 0);

    prefix_sup = 1'b1;
    rec(32'h20, 1, 1); h_a = rec_hdr; cyc();
    chk(fep == 5 && hdr_log == h_a, "R2 direct load", 128'(fep), 5);
    chk(pfx_present == 1'b1, "R5 prefix kept with support", 128'(pfx_present), 1);
    prefix_sup = 1'b0;
    rec(32'h8, 0, 1); cyc();
    chk(fep == 3 && hdr_log == 0, "R4 header zeroed without valid flag", hdr_log, 0);
    chk(pfx_present == 1'b0 && pfx_log == 0, "R5 prefix dropped without support", pfx_log, 0);
    wr(32'h8); cyc();
    chk(fep == 0 && uncor_sts == 32'h20 && hdr_log == 0, "R6 clear to empty log", 128'(uncor_sts), 128'h20);

    multi_en = 1'b1; prefix_sup = 1'b1;
    wr(32'hffff_ffff); cyc();
    rec(32'h4, 1, 0); cyc();
    rec(32'h80, 1, 1); h_a = rec_hdr; cyc();
    rec(32'h200, 0, 0); cyc();
    chk(fep == 2 && uncor_sts == 32'h284, "R3 queued behind first error", 128'(uncor_sts), 128'h284);
    wr(32'h80); cyc();
    chk(uncor_sts == 32'h284 && fep == 2, "R8 clear of queued bit undone", 128'(uncor_sts), 128'h284);
    wr(32'h4); cyc();
    chk(fep == 7 && hdr_log == h_a && uncor_sts == 32'h280, "R7 pop oldest", 128'(fep), 7);
    wr(32'h80); cyc();
    chk(fep == 9 && hdr_log == 0, "R7 second pop in order", 128'(fep), 9);
    wr(32'h200); cyc();
    chk(fep == 0 && hdr_log == 0 && pfx_present == 0, "R6 clear with empty queue", 128'(fep), 0);

    rec(32'h2, 1, 0); cyc();
    for (int b = 2; b < 10; b++) begin rec(32'(1) << b, 1, 0); cyc(); end
    rec(32'h400, 1, 0); cyc();
    chk(ovf_pulse == 1'b1 && uncor_sts[10], "R3 overflow pulse on full queue", 128'(ovf_pulse), 1);
    cyc();
    chk(ovf_pulse == 1'b0, "R3 overflow lasts one cycle", 128'(ovf_pulse), 0);
    for (int b = 1; b < 9; b++) begin
      wr(32'(1) << b); cyc();
      chk(fep == 5'(b + 1), "R7 drain in arrival order", 128'(fep), 128'(b + 1));
    end
    wr(32'h200); cyc();
    chk(fep == 0, "R6 drained queue clears", 128'(fep), 0);

    wr(32'hffff_ffff); cyc();
    rec(32'h10, 1, 0); cyc();
    rec(32'h40, 1, 0); cyc();
    rec(32'h80, 1, 0); cyc();
    multi_en = 1'b0;
    wr(32'h0); cyc();
    multi_en = 1'b1;
    wr(32'h10); cyc();
    chk(fep == 0 && hdr_log == 0, "R9 flush leaves nothing to pop", 128'(fep), 0);

    wr(32'hffff_ffff); rec(32'h800, 1, 0); h_a = rec_hdr; cyc();
    chk(fep == 11 && uncor_sts == 32'h800 && hdr_log == h_a, "R12 write before record", 128'(uncor_sts), 128'h800);

    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom % 16;
      if ($urandom % 40 == 0) multi_en = ~multi_en;
      prefix_sup = ($urandom % 4) != 0;
      if ($urandom % 2 == 0) begin
        if (r == 0) rec(32'h0, 1, 1);
        else if (r == 1) rec(32'h3 << ($urandom % 6), 1, 1);
        else rec(32'(1) << ($urandom % 6), ($urandom % 2) == 1, ($urandom % 2) == 1);
      end
      if ($urandom % 3 == 0) begin
        if ($urandom % 2 == 0) wr(32'(1) << mf);
        else wr($urandom & 32'h3f);
      end
      cyc();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule